// File: doc/BRIEF.md
# SPI Memory Command Front-End

This block is the serial slave side of a byte-addressed memory. It watches a four-wire serial bus (active-low select, serial clock, serial data in, serial data out), recovers one command per select window, and turns it into single-cycle requests on a synchronous memory port with 16-bit byte addresses and 8-bit data. Memory reads come back as serial data. An 8-bit status register holds a write-enable latch and six user bits. Both idle polarities of the serial clock (modes 0 and 3) work. Input bits are taken on the rising edge of the serial clock, and output bits move on the falling edge.

All bus pins are sampled by the block's own clock `clk`, so the serial clock is treated as data. The controller is a state machine with these states:

- ST_IDLE: select is high.
- ST_OPC: collecting the command byte.
- ST_AHI / ST_ALO: the high and low address bytes.
- ST_RDAT: streaming memory data out.
- ST_WDAT: taking memory data in.
- ST_SRRD: streaming the status register.
- ST_SRWR: taking a new status value.
- ST_DONE: the command has finished and the rest of the frame is ignored.
- ST_LOCK: the command was rejected and the rest of the frame is ignored.

The transitions are as follows:

- Select high moves any state to ST_IDLE. Select low moves ST_IDLE to ST_OPC.
- A completed byte in ST_OPC moves to one of these states:
  - ST_AHI for a read command, or for a write command while the latch is set.
  - ST_SRRD for a status read.
  - ST_SRWR for a status write while the latch is set.
  - ST_DONE for latch set or latch clear.
  - ST_LOCK for anything else, including a write or status write while the latch is clear.
- ST_AHI moves to ST_ALO. ST_ALO moves to ST_RDAT for a read or to ST_WDAT for a write.
- ST_SRWR moves to ST_DONE after one byte.
- ST_RDAT, ST_WDAT, ST_SRRD, ST_DONE and ST_LOCK hold until select rises.

Top module: `spi_mem_frontend`

## Requirements
- R1: While `cs_n` is high, `so_oe` is low, `mem_we` and `mem_re` stay low, and activity on `sck` or `si` changes no state.
- R2: Command, address and data bits are taken MSB first on rising `sck`. A read (command 0x03) followed by the high address byte and then the low address byte returns that memory byte on `so`, MSB first, with `so_oe` high. `so` changes only after a falling `sck`.
- R3: Each further byte clocked during a read returns the next address. The address wraps from 0xFFFF to 0x0000.
- R4: A write (command 0x02), issued while the latch is set, stores each complete data byte at the addressed location. The address then increments and wraps from 0xFFFF to 0x0000. Each stored byte produces exactly one `mem_we` pulse.
- R5: A write, or a status write (command 0x01), issued while the latch (status bit 1) is clear changes neither memory nor the status register.
- R6: Command 0x06 sets status bit 1. Command 0x04 clears it.
- R7: A status read (command 0x05) returns the status byte on every byte that follows. Bit 1 of that byte is the latch and bit 0 reads 0.
- R8: A status write issued while the latch is set loads status bits 7 to 2 from the data byte. Data bits 1 and 0 have no effect.
- R9: The latch clears when select rises at the end of a write or status-write frame that stored at least one complete byte.
- R10: After an unrecognised command, the rest of the frame is ignored. `so_oe` stays low, no memory access occurs, and later bytes in the frame are not decoded as commands.
- R11: Only the first byte of a frame is decoded as a command. Bytes after a latch-set or latch-clear command have no effect.
- R12: A byte cut short by select rising is discarded. It does not count as a stored byte, and the next frame starts from its first bit.
- R13: Both `sck` idle levels (mode 0 and mode 3) work, provided each `sck` high and low phase lasts at least 3 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; each low window carries one command |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master; valid while `so_oe` is high |
| so_oe | output | 1 | Output enable for the external tri-state driver of `so` |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_re | output | 1 | One-cycle memory read strobe; data is expected on `mem_rdata` one cycle later |
| mem_rdata | input | 8 | Memory read data |

## Verification
A rising `sck` is seen at the first `clk` edge after it arrives. `mem_we` and `mem_re` pulse in the cycle before that edge when the eighth bit of a byte lands. The fetched byte is buffered two edges later, and `so` moves one `clk` edge after a falling `sck` is seen. The bench holds every `sck` phase for four `clk` cycles and reads `so` and `so_oe` just before it raises `sck`, which is at least three cycles after the output could have moved. Strobes and the idle bus are checked on every falling `clk` edge, halfway between input changes. Latch and status effects are checked by a status read in the following frame, after select has risen.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W  = 8;
    localparam int WEL_BIT = 1;

    localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_RDAT,
        ST_WDAT,
        ST_SRRD,
        ST_SRWR,
        ST_DONE,
        ST_LOCK
    } fe_state_t;

endpackage

// File: rtl/spi_fe_edge.sv
// Edge finder for the bus pins, working in the block clock domain.
module spi_fe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Serial clock edges count only while the frame is open.
    assign sck_rise = ~cs_n & sck & ~sck_q;
    assign sck_fall = ~cs_n & ~sck & sck_q;
    assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spi_fe_rx.sv
// Input deserialiser: collects W bits, MSB first.
module spi_fe_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sck_rise,
    input  logic         si,
    output logic         byte_done,
    output logic [W-1:0] byte_val,
    output logic         at_boundary
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-2:0]  sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (cs_n) begin
            // A partial byte is dropped here when select rises.
            cnt <= '0;
        end else if (sck_rise) begin
            sh  <= {sh[W-3:0], si};
            cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
        end
    end

    assign byte_val    = {sh, si};
    assign byte_done   = sck_rise && (cnt == CW'(W-1));
    assign at_boundary = (cnt == '0);
endmodule

// File: rtl/spi_fe_tx.sv
// Output serialiser: loads a byte, then shifts it out MSB first.
module spi_fe_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         so
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh <= '0;
        else if (load)  sh <= din;
        else if (shift) sh <= {sh[W-2:0], 1'b0};
    end

    assign so = sh[W-1];
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spi_fe_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [7:0]  SR_WMASK = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    localparam int         AW2     = 2 * BYTE_W;
    localparam logic [7:0] SR_MASK = SR_WMASK & 8'hFC;

    fe_state_t         state_q, state_d;
    logic              sck_rise, sck_fall, cs_rise;
    logic              byte_done, at_boundary;
    logic [BYTE_W-1:0] byte_val;
    logic [BYTE_W-1:0] addr_hi;
    logic [AW2-1:0]    addr_cat;
    logic [ADDR_W-1:0] addr_q;
    logic              op_rd;
    logic              wel_q;
    logic              committed;
    logic [7:0]        sr_q;
    logic [7:0]        status_w;
    logic              rd_pend;
    logic [7:0]        rd_buf;
    logic              tx_state;
    logic              st_lock;
    logic [7:0]        tx_din;

    spi_fe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_fe_rx #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
        .byte_done(byte_done), .byte_val(byte_val), .at_boundary(at_boundary)
    );

    spi_fe_tx #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(sck_fall && at_boundary && tx_state),
        .shift(sck_fall && !at_boundary),
        .din(tx_din), .so(so)
    );

    assign addr_cat = {addr_hi, byte_val};
    assign status_w = (sr_q & SR_MASK) | (8'(wel_q) << WEL_BIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else if (state_q == ST_IDLE) begin
            state_d = ST_OPC;
        end else if (byte_done) begin
            unique case (state_q)
                ST_OPC: begin
                    if (byte_val == OP_READ)                 state_d = ST_AHI;
                    else if (byte_val == OP_WRITE)           state_d = wel_q ? ST_AHI : ST_LOCK;
                    else if (byte_val == OP_RDSR)            state_d = ST_SRRD;
                    else if (byte_val == OP_WRSR)            state_d = wel_q ? ST_SRWR : ST_LOCK;
                    else if (byte_val == OP_WREN ||
                             byte_val == OP_WRDI)            state_d = ST_DONE;
                    else                                     state_d = ST_LOCK;
                end
                ST_AHI:  state_d = ST_ALO;
                ST_ALO:  state_d = op_rd ? ST_RDAT : ST_WDAT;
                ST_SRWR: state_d = ST_DONE;
                default: state_d = state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_state  = (state_q == ST_RDAT) || (state_q == ST_SRRD);
        st_lock   = (state_q == ST_LOCK);
        so_oe     = ~cs_n && tx_state;
        mem_re    = byte_done && (((state_q == ST_ALO) && op_rd) || (state_q == ST_RDAT));
        mem_we    = byte_done && (state_q == ST_WDAT);
        mem_addr  = (state_q == ST_ALO) ? ADDR_W'(addr_cat) : addr_q;
        mem_wdata = byte_val;
        tx_din    = (state_q == ST_SRRD) ? status_w : rd_buf;
    end

    // Address, latch, status and read buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi   <= '0;
            addr_q    <= '0;
            op_rd     <= 1'b0;
            wel_q     <= 1'b0;
            committed <= 1'b0;
            sr_q      <= '0;
            rd_pend   <= 1'b0;
            rd_buf    <= '0;
        end else begin
            rd_pend <= mem_re;
            if (rd_pend) rd_buf <= mem_rdata;
            if (cs_rise && committed) wel_q <= 1'b0;
            if (state_q == ST_IDLE) committed <= 1'b0;
            if (byte_done) begin
                case (state_q)
                    ST_OPC: begin
                        op_rd <= (byte_val == OP_READ);
                        if (byte_val == OP_WREN) wel_q <= 1'b1;
                        if (byte_val == OP_WRDI) wel_q <= 1'b0;
                    end
                    ST_AHI:  addr_hi <= byte_val;
                    ST_ALO:  addr_q  <= op_rd ? ADDR_W'(addr_cat) + 1'b1 : ADDR_W'(addr_cat);
                    ST_RDAT: addr_q  <= addr_q + 1'b1;
                    ST_WDAT: begin
                        addr_q    <= addr_q + 1'b1;
                        committed <= 1'b1;
                    end
                    ST_SRWR: begin
                        sr_q      <= byte_val & SR_MASK;
                        committed <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so,
    input logic so_oe,
    input logic mem_we,
    input logic mem_re,
    input logic wel,
    input logic locked,
    input logic byte_done,
    input logic sck_fall,
    input logic cs_rise
);
    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!so_oe && !mem_we && !mem_re));

    // R2
    so_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !$stable(so)) |-> $past(sck_fall));

    // R5
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    // R6
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(byte_done));

    // R9
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> ($past(cs_rise) || $past(byte_done)));

    // R10
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!so_oe && !mem_we && !mem_re));
endmodule

bind spi_mem_frontend spi_mem_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
    .mem_we(mem_we), .mem_re(mem_re), .wel(wel_q), .locked(st_lock),
    .byte_done(byte_done), .sck_fall(sck_fall), .cs_rise(cs_rise)
);

// File: tb/sim_spi_mem_frontend.sv
`timescale 1ns/1ps
module sim_spi_mem_frontend;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe, mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0, failures = 0, we_cnt = 0, re_cnt = 0;
    bit run = 0, done = 0;

    logic [7:0] txb [16];
    logic [7:0] rxb [16];
    bit         oeb [16];

    logic [7:0] bmem    [int];
    logic [7:0] ref_mem [int];
    logic [7:0] ref_sr  = 8'h00;
    bit         ref_wel = 0;

    always #2.5 clk = ~clk;

    spi_mem_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] ref_rd(int a);
        int k = a & 16'hFFFF;
        return ref_mem.exists(k) ? ref_mem[k] : init_val(k);
    endfunction

    function automatic logic [7:0] exp_status();
        return (ref_sr & 8'hFC) | (8'(ref_wel) << 1);
    endfunction

    // Behavioural array: one-cycle synchronous read
    always @(posedge clk) begin
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)]
                                                              : init_val(int'(mem_addr));
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison, halfway between input changes
    always @(negedge clk) begin
        if (rst_n && run) begin
            if (cs_n) chk("R1 idle bus quiet", {29'd0, so_oe, mem_we, mem_re}, 0);
            if (mem_we) begin
                we_cnt++;
                chk("R5 write strobe needs latch", 32'(ref_wel), 1);
            end
            if (mem_re) re_cnt++;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame(input bit m3, input int nb, input int xbits, input logic [7:0] xval);
        sck = m3; wt(H);
        we_cnt = 0; re_cnt = 0;
        cs_n = 1'b0; wt(H);
        for (int k = 0; k < nb; k++) begin
            oeb[k] = 1;
            for (int i = 7; i >= 0; i--) begin
                sck = 1'b0; si = txb[k][i]; wt(H);
                rxb[k][i] = so;
                if (!so_oe) oeb[k] = 0;
                sck = 1'b1; wt(H);
            end
        end
        for (int i = 0; i < xbits; i++) begin
            sck = 1'b0; si = xval[7-i]; wt(H);
            sck = 1'b1; wt(H);
        end
        if (!m3) begin sck = 1'b0; wt(H); end
        cs_n = 1'b1; wt(H);
        sck = m3;
    endtask

    task automatic rdsr(input bit m3, input int n, input string req);
        txb[0] = 8'h05;
        for (int j = 1; j <= n; j++) txb[j] = 8'hA5;
        frame(m3, n + 1, 0, 8'h00);
        for (int j = 1; j <= n; j++) begin
            chk({req, " status byte"}, rxb[j], exp_status());
            chk({req, " status driven"}, 32'(oeb[j]), 1);
        end
    endtask

    task automatic single(input bit m3, input logic [7:0] op);
        txb[0] = op;
        frame(m3, 1, 0, 8'h00);
        if (op == 8'h06) ref_wel = 1;
        if (op == 8'h04) ref_wel = 0;
    endtask

    task automatic mem_write(input bit m3, input int a, input int n, input int xbits, input string req);
        txb[0] = 8'h02; txb[1] = 8'(a >> 8); txb[2] = 8'(a);
        frame(m3, 3 + n, xbits, 8'hF0);
        if (ref_wel) begin
            for (int j = 0; j < n; j++) ref_mem[(a + j) & 16'hFFFF] = txb[3 + j];
            chk({req, " store count"}, we_cnt, n);
            if (n > 0) ref_wel = 0;
        end else begin
            chk({req, " store count"}, we_cnt, 0);
        end
    endtask

    task automatic mem_read(input bit m3, input int a, input int n, input string req);
        txb[0] = 8'h03; txb[1] = 8'(a >> 8); txb[2] = 8'(a);
        for (int j = 0; j < n; j++) txb[3 + j] = 8'h00;
        frame(m3, 3 + n, 0, 8'h00);
        chk({req, " command byte not driven"}, 32'(oeb[0]), 0);
        for (int j = 0; j < n; j++) begin
            chk({req, " read data"}, rxb[3 + j], ref_rd(a + j));
            chk({req, " read driven"}, 32'(oeb[3 + j]), 1);
        end
    endtask

    task automatic wrsr(input bit m3, input logic [7:0] v);
        txb[0] = 8'h01; txb[1] = v;
        frame(m3, 2, 0, 8'h00);
        if (ref_wel) begin
            ref_sr  = v & 8'hFC;
            ref_wel = 0;
        end
    endtask

    initial begin
        wt(5);
        chk("R1 reset quiet", {29'd0, so_oe, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        wt(3);
        run = 1;

        rdsr(0, 2, "R7");

        // R5: write with latch clear
        txb[3] = 8'hAA;
        mem_write(0, 16'h1000, 1, 0, "R5");
        mem_read(0, 16'h1000, 1, "R5");

        // R11: latch-set then a latch-clear byte in the same frame
        txb[0] = 8'h06; txb[1] = 8'h04;
        frame(0, 2, 0, 8'h00);
        ref_wel = 1;
        rdsr(0, 1, "R11");

        // R4, R9, R2, R3
        txb[3] = 8'h11; txb[4] = 8'h22; txb[5] = 8'h33;
        mem_write(0, 16'h1000, 3, 0, "R4");
        rdsr(0, 1, "R9");
        mem_read(0, 16'h1000, 4, "R2 R3");

        // R13 mode 3 with wrap, R4 wrap, R3 wrap
        single(1, 8'h06);
        txb[3] = 8'h77; txb[4] = 8'h88;
        mem_write(1, 16'hFFFF, 2, 0, "R4 R13 wrap");
        mem_read(1, 16'hFFFE, 3, "R3 R13 wrap");

        // R8, R6, R5 on status
        single(0, 8'h06);
        wrsr(0, 8'hFF);
        rdsr(0, 1, "R8");
        single(0, 8'h06);
        rdsr(0, 2, "R6 set");
        single(0, 8'h04);
        rdsr(0, 1, "R6 clear");
        wrsr(0, 8'h00);
        rdsr(0, 1, "R5 status");
        single(1, 8'h06);
        wrsr(1, 8'h0D);
        rdsr(1, 1, "R8 low bits");

        // R10: unknown command, then bytes that look like commands
        txb[0] = 8'hAB; txb[1] = 8'h06; txb[2] = 8'h03; txb[3] = 8'h00; txb[4] = 8'h00;
        frame(0, 5, 0, 8'h00);
        for (int j = 0; j < 5; j++) chk("R10 output off", 32'(oeb[j]), 0);
        chk("R10 no reads", re_cnt, 0);
        chk("R10 no writes", we_cnt, 0);
        rdsr(0, 1, "R10");

        // R12: partial command, then partial data byte
        txb[0] = 8'h00;
        frame(0, 0, 7, 8'h06);
        rdsr(0, 1, "R12 partial command");
        single(0, 8'h06);
        txb[3] = 8'h5C;
        mem_write(0, 16'h2000, 1, 4, "R12");
        mem_read(0, 16'h2000, 2, "R12");
        rdsr(0, 1, "R12 R9");

        // R1: bus activity with select high
        for (int i = 0; i < 24; i++) begin
            si = i[0] ^ i[2]; sck = ~sck; wt(H);
        end
        sck = 1'b0; wt(H);
        rdsr(0, 1, "R1 ignored traffic");
        mem_read(0, 16'h1001, 2, "R1 ignored traffic");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule